// File: doc/BRIEF.md
# Seven-to-one multi-lane display link serializer

This block turns a 28-bit pixel word into four serial data lanes. It also drives a fifth lane that carries a clock pattern framing each group of seven bits. The word is made of 24 colour bits and four panel control bits: line sync, frame sync, data ready and one spare bit. The block captures this word once per pixel clock, on the pixel clock's falling edge. Each lane then sends seven bits of the word during the following pixel period.

The serial side runs on a bit clock at seven times the pixel rate. This bit clock comes from outside the block, and its rising edges line up with the pixel clock. The block detects each rising edge of the pixel clock in the bit-clock domain. That edge marks a frame boundary, where all five shift registers load together. A power-down input holds every lane low and empties the shifters. After power-down is released, output resumes cleanly at the next frame boundary.

Top module: `lvds_tx_7to1`

## Requirements
- R1: The word is taken from `rgb_i`/`ctl_i` at the falling edge of `pclk_i`. Any change to these inputs after that edge, within the same pixel period, has no effect on what the lanes send.
- R2: The packed word is `{ctl_i, rgb_i}` (ctl in bits 27:24, with ctl_i[0] line sync, [1] frame sync, [2] data ready, [3] spare). Lane n (n = 0..3) carries word bits [7n+6:7n].
- R3: Within each frame, every data lane sends its most significant bit (word bit 7n+6) first and its least significant bit (7n) last, one bit per bit-clock cycle.
- R4: The clock lane sends 1,1,0,0,0,1,1 (pattern 7'b1100011, MSB first) in every frame, aligned with the data bits.
- R5: A frame starts at the first rising edge of `clk_bit_i` after `pclk_i` rises. A word captured in one pixel period is sent in full during the next one.
- R6: While `pd_i` is high, all four data lanes and the clock lane are low.
- R7: After `pd_i` falls at a frame boundary, the clock pattern resumes in the first frame and the data lanes send zeros in that frame. The first word captured after the release is sent in the frame after that.
- R8: During reset, and until the first frame boundary after reset, all lanes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_i | input | 1 | Bit clock, seven times the pixel clock, edge-aligned with it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pclk_i | input | 1 | Pixel clock; its falling edge captures the word |
| pd_i | input | 1 | Power-down, active high |
| rgb_i | input | 24 | Colour data, word bits 23:0 |
| ctl_i | input | 4 | Control bits: [0] line sync, [1] frame sync, [2] data ready, [3] spare |
| lane_o | output | 4 | Serial data lanes, lane n on bit n |
| clk_lane_o | output | 1 | Forwarded clock lane |

## Verification
The hardest case to reach is the power-down release. Only one frame shows the mixed state: the clock pattern is already running while the data lanes still carry the zero word captured during power-down. The stimulus raises and lowers `pd_i` exactly at pixel clock rising edges, in two separate episodes. The bench then predicts the zero frame and the following live frame. A second case that is hard to reach is a late input change: the stimulus flips the whole word after the falling edge in every fifth frame. This shows that only the value held at that edge reaches the lanes.

// File: rtl/lvds_tx_pkg.sv
package lvds_tx_pkg;
  localparam int unsigned RGB_W_DEF = 24;
  localparam int unsigned CTL_W_DEF = 4;
  localparam int unsigned BPL_DEF   = 7;
  localparam logic [BPL_DEF-1:0] CLK_PAT_DEF = 7'b1100011;
endpackage

// File: rtl/lvds_word_capture.sv
module lvds_word_capture #(
  parameter int unsigned W = 28
) (
  input  logic         pclk_i,
  input  logic         rst_ni,
  input  logic         pd_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  always_ff @(negedge pclk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= '0;
    else if (pd_i) word_o <= '0;
    else           word_o <= word_i;
  end
endmodule

// File: rtl/lvds_frame_ctl.sv
module lvds_frame_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pclk_i,
  output logic load_o
);
  logic pclk_d;

  // reset high so a pixel clock already high at reset release is not a boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pclk_d <= 1'b1;
    else         pclk_d <= pclk_i;
  end

  assign load_o = pclk_i & ~pclk_d;

  // R5
  single_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/lvds_lane_shift.sv
module lvds_lane_shift #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [N-1:0] par_i,
  output logic         ser_o
);
  logic [N-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (clr_i)  sr_q <= '0;
    else if (load_i) sr_q <= par_i;
    else             sr_q <= {sr_q[N-2:0], 1'b0};
  end

  assign ser_o = sr_q[N-1];

  // R6
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sr_q == '0));

  // R3
  msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (ser_o == $past(par_i[N-1])));

  // R3
  shift_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i) |=> (ser_o == $past(sr_q[N-2])));
endmodule

// File: rtl/lvds_tx_7to1.sv
module lvds_tx_7to1
  import lvds_tx_pkg::*;
#(
  parameter int unsigned RGB_W = RGB_W_DEF,
  parameter int unsigned CTL_W = CTL_W_DEF,
  parameter int unsigned BPL   = BPL_DEF,
  parameter logic [BPL-1:0] CLK_PAT = CLK_PAT_DEF,
  localparam int unsigned WORD_W = RGB_W + CTL_W,
  localparam int unsigned LANES  = WORD_W / BPL
) (
  input  logic             clk_bit_i,
  input  logic             rst_ni,
  input  logic             pclk_i,
  input  logic             pd_i,
  input  logic [RGB_W-1:0] rgb_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic [LANES-1:0] lane_o,
  output logic             clk_lane_o
);
  logic [WORD_W-1:0] word_q;
  logic              load;
  logic [LANES-1:0]  lane_ser;
  logic              clk_ser;

  lvds_word_capture #(.W(WORD_W)) u_cap (
    .pclk_i (pclk_i),
    .rst_ni (rst_ni),
    .pd_i   (pd_i),
    .word_i ({ctl_i, rgb_i}),
    .word_o (word_q)
  );

  lvds_frame_ctl u_frm (
    .clk_i  (clk_bit_i),
    .rst_ni (rst_ni),
    .pclk_i (pclk_i),
    .load_o (load)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lvds_lane_shift #(.N(BPL)) u_sh (
      .clk_i  (clk_bit_i),
      .rst_ni (rst_ni),
      .clr_i  (pd_i),
      .load_i (load),
      .par_i  (word_q[g*BPL +: BPL]),
      .ser_o  (lane_ser[g])
    );
  end

  lvds_lane_shift #(.N(BPL)) u_clk_sh (
    .clk_i  (clk_bit_i),
    .rst_ni (rst_ni),
    .clr_i  (pd_i),
    .load_i (load),
    .par_i  (CLK_PAT),
    .ser_o  (clk_ser)
  );

  // quiet lanes immediately on power-down, not one bit later
  assign lane_o     = lane_ser & {LANES{~pd_i}};
  assign clk_lane_o = clk_ser & ~pd_i;

  // R4
  clk_lane_lead_chk: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    (load && !pd_i) |=> (pd_i || clk_lane_o == CLK_PAT[BPL-1]));

  // R6
  pd_quiet_chk: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    $past(pd_i) && pd_i |-> (lane_o == '0 && !clk_lane_o));
endmodule

// File: tb/sim_lvds_tx_7to1.sv
module sim_lvds_tx_7to1;
  localparam logic [6:0] PAT = 7'b1100011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pclk = 1'b0;
  logic        pd = 1'b0;
  logic [27:0] drv = '0;
  logic [3:0]  lane;
  logic        clk_lane;

  int unsigned n_cmp = 0, n_bad = 0;
  int unsigned cyc = 0, ph = 0, frame = 0;
  logic [27:0] capt = '0, fword = '0;
  bit started = 0, prev_pd = 0, after_pd = 0, late = 0, late_cur = 0, done = 0;

  always #4 clk = ~clk;

  lvds_tx_7to1 u0 (
    .clk_bit_i  (clk),
    .rst_ni     (rst_n),
    .pclk_i     (pclk),
    .pd_i       (pd),
    .rgb_i      (drv[23:0]),
    .ctl_i      (drv[27:24]),
    .lane_o     (lane),
    .clk_lane_o (clk_lane)
  );

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s frame %0d bit %0d: actual %b expected %b", tag, frame, ph, act, exp);
    end
  endtask

  function automatic logic [27:0] pick_word(int unsigned f);
    case (f)
      1: return 28'hFFFFFFF;
      2: return 28'h0000000;
      3: return 28'h5555555;
      4: return 28'hAAAAAAA;
      5: return 28'h8102040;   // MSB of each lane only
      6: return 28'h0204081;   // LSB of each lane only
      default: return 28'($urandom);
    endcase
  endfunction

  always @(negedge clk) begin
    logic [3:0] exp_d;
    logic       exp_c;
    string      tag;
    cyc++;
    // sample
    if (!rst_n) begin
      chk("R8 reset", {clk_lane, lane}, 5'b0);
    end else begin
      if (pd)            begin exp_d = '0; exp_c = 1'b0; tag = "R6"; end
      else if (!started) begin exp_d = '0; exp_c = 1'b0; tag = "R8"; end
      else begin
        for (int n = 0; n < 4; n++) exp_d[n] = fword[7*n + 6 - ph];
        exp_c = PAT[6 - ph];
        tag = after_pd ? "R7" : (late_cur ? "R1" : "R2 R3 R5");
      end
      chk({tag, " data"}, {1'b0, lane}, {1'b0, exp_d});
      chk(pd ? "R6 clk" : (started ? "R4" : "R8 clk"), {4'b0, clk_lane}, {4'b0, exp_c});
    end
    // advance pixel phase and stimulus
    if (ph == 6) begin
      ph = 0;
      pclk = 1'b1;
      if (rst_n) begin
        started  = 1;
        fword    = capt;
        late_cur = late;
        frame++;
        prev_pd  = pd;
        pd       = (frame >= 30 && frame < 36) || (frame >= 70 && frame < 72);
        after_pd = prev_pd && !pd;
        drv      = pick_word(frame);
        late     = (frame % 5 == 2) && !pd;
        if (frame == 120) done = 1;
      end
    end else begin
      ph++;
      if (ph == 4) begin
        pclk = 1'b0;
        capt = (!rst_n || pd) ? '0 : drv;
      end
      if (ph == 5 && late) drv = ~drv;  // R1: change after capture edge
    end
    if (!rst_n && cyc >= 20 && ph == 2) rst_n = 1'b1;
  end

  initial begin
    void'($urandom(32'd20240607));
    wait (done);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule